// File: doc/BRIEF.md
# Warp Operand Collector

This block sits between the decode and execute stages of a SIMT pipeline. A decoded warp instruction is taken into one of several parallel collector slots. Each of its source registers is turned into a read request, tagged with the slot number and the operand index, and queued at the register-file bank that holds the register. As an external bank allocator grants the heads of those queues, the block clears the matching operand's pending bit. A slot whose operands have all arrived is sent downstream, one per cycle, whenever the execute-side pipeline register is empty.

Register data never enters the block. Operands are tracked only by tag and ready bit. A destination write coming back from writeback holds its bank for that cycle. The read request of that bank is then withdrawn and any grant on it is ignored. This gives writes priority over reads. Because every operand has its own per-bank queue, a conflict on one bank does not hold up reads waiting on other banks.

Top module: `opnd_collector`

## Requirements
- R1: After reset no slot is occupied, `out_valid` and every `rd_req` bit are 0, and `in_ready` is 1.
- R2: Source slot k (bits k*REG_W upward of `in_src_reg`, valid when `in_src_vld[k]`) of an instruction from warp w reading register r is queued at bank (r + w) mod NUM_BANKS. Each bank serves its requests first in, first out. Operands of one instruction enter in ascending slot order. `rd_req_cu`/`rd_req_op` (field b, CU_W/OP_W bits wide) show the head's slot and operand index.
- R3: An instruction is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when (a) a slot is free or one dispatches in the same cycle, and (b) for every bank, the occupancy at the start of the cycle plus the instruction's operands mapped to that bank is at most Q_DEPTH.
- R4: Free slots are reused last-freed-first. After reset, allocations go to slots NUM_CU-1 down to 0. A slot dispatched in a cycle is the one given to an instruction taken in that same cycle.
- R5: A `rd_gnt[b]` while `rd_req[b]` is 1 removes the head of bank b and clears that operand's pending bit. A grant on a bank without a request changes nothing.
- R6: While `wb_valid` is 1, bank (`wb_reg` + `wb_warp`) mod NUM_BANKS is reserved. Its `rd_req` bit is 0 and a grant on it is ignored.
- R7: A slot whose last operand is granted in cycle t is ready from cycle t+1. A ready slot is sent out (`out_valid`, `out_tag`, `out_warp`) only in a cycle with `out_empty` at 1.
- R8: The dispatch search is round-robin, starting one past the slot that last dispatched (slot 0 counts as last after reset). At most one slot dispatches per cycle.
- R9: An instruction with no valid source operand is ready in the cycle after it is taken.
- R10: No bank queue ever holds more than Q_DEPTH entries, and occupied plus free slots always equal NUM_CU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode register holds an instruction |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_tag | input | TAG_W | Instruction identifier |
| in_warp | input | WARP_W | Warp number |
| in_src_vld | input | NUM_SRC | Per-slot source valid |
| in_src_reg | input | NUM_SRC*REG_W | Source register numbers, slot k at k*REG_W |
| wb_valid | input | 1 | Destination write this cycle |
| wb_warp | input | WARP_W | Warp of the write |
| wb_reg | input | REG_W | Register written |
| rd_req | output | NUM_BANKS | Bank has a grantable head request |
| rd_req_cu | output | NUM_BANKS*CU_W | Slot of each bank's head request |
| rd_req_op | output | NUM_BANKS*OP_W | Operand index of each bank's head request |
| rd_gnt | input | NUM_BANKS | Read grants from the bank allocator |
| out_empty | input | 1 | Downstream register is empty |
| out_valid | output | 1 | Instruction dispatched this cycle |
| out_tag | output | TAG_W | Tag of the dispatched instruction |
| out_warp | output | WARP_W | Warp of the dispatched instruction |

## Verification
The directed patterns each target one behaviour:
- Single operands on distinct banks show the slot allocation order.
- Two operands sharing a bank show FIFO order inside that bank.
- A grant on a reserved bank and a grant on an idle bank tell a grant that is taken apart from one that is ignored.
- A full slot set blocked by `out_empty` separates readiness from dispatch.
- Every operand aimed at one bank fills that queue and shows back-pressure while slots are still free.
- A no-source instruction taken in the same cycle a slot dispatches shows slot reuse and its place in the round-robin order.

A long pseudo-random stretch then mixes writes, sparse grants and stalls. There, a behavioural queue model separates correct interleavings from ordering slips.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int OC_CU     = 4;
    localparam int OC_BANKS  = 8;
    localparam int OC_SRC    = 4;
    localparam int OC_QDEPTH = 8;

    // bank holding a register of a given warp
    function automatic int bank_of(int unsigned reg_num, int unsigned warp, int unsigned nbanks);
        return int'((reg_num + warp) % nbanks);
    endfunction
endpackage

// File: rtl/oc_bank_fifo.sv
module oc_bank_fifo #(
    parameter int DEPTH = oc_pkg::OC_QDEPTH,
    parameter int EW    = 4,
    parameter int NPUSH = oc_pkg::OC_SRC
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(NPUSH+1)-1:0]     push_n,
    input  logic [NPUSH-1:0][EW-1:0]       push_e,
    input  logic                           pop,
    output logic                           head_vld,
    output logic [EW-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // writes land past the live entries; room was checked upstream
        for (int i = 0; i < NPUSH; i++) begin
            if (i < int'(push_n))
                s_d.mem[PW'(int'(s_q.rd) + int'(s_q.cnt) + i)] = push_e[i];
        end
        if (pop)
            s_d.rd = s_q.rd + 1'b1;
        s_d.cnt = s_q.cnt + CW'(push_n) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_vld = (s_q.cnt != '0);
    assign head     = s_q.mem[s_q.rd];
    assign count    = s_q.cnt;
endmodule

// File: rtl/oc_free_stack.sv
module oc_free_stack #(
    parameter int N = oc_pkg::OC_CU
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [$clog2(N)-1:0]     push_id,
    input  logic                     pop,
    output logic [$clog2(N)-1:0]     pop_id,
    output logic                     avail,
    output logic [$clog2(N+1)-1:0]   count
);
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N+1);

    typedef struct packed {
        logic [N-1:0][IW-1:0] stk;
        logic [CW-1:0]        cnt;
    } stack_st_t;

    stack_st_t s_d, s_q;

    // a slot released this cycle bypasses the stack and is handed out first
    assign pop_id = push ? push_id : s_q.stk[IW'(s_q.cnt - 1'b1)];
    assign avail  = push || (s_q.cnt != '0);
    assign count  = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (push && !pop) begin
            s_d.stk[IW'(s_q.cnt)] = push_id;
            s_d.cnt               = s_q.cnt + 1'b1;
        end else if (pop && !push) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) s_q.stk[i] <= IW'(i);
            s_q.cnt <= CW'(N);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/opnd_collector.sv
module opnd_collector #(
    parameter int NUM_CU    = oc_pkg::OC_CU,
    parameter int NUM_BANKS = oc_pkg::OC_BANKS,
    parameter int NUM_SRC   = oc_pkg::OC_SRC,
    parameter int Q_DEPTH   = oc_pkg::OC_QDEPTH,
    parameter int REG_W     = 8,
    parameter int WARP_W    = 6,
    parameter int TAG_W     = 8,
    parameter int CU_W      = $clog2(NUM_CU),
    parameter int OP_W      = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [TAG_W-1:0]            in_tag,
    input  logic [WARP_W-1:0]           in_warp,
    input  logic [NUM_SRC-1:0]          in_src_vld,
    input  logic [NUM_SRC*REG_W-1:0]    in_src_reg,
    input  logic                        wb_valid,
    input  logic [WARP_W-1:0]           wb_warp,
    input  logic [REG_W-1:0]            wb_reg,
    output logic [NUM_BANKS-1:0]        rd_req,
    output logic [NUM_BANKS*CU_W-1:0]   rd_req_cu,
    output logic [NUM_BANKS*OP_W-1:0]   rd_req_op,
    input  logic [NUM_BANKS-1:0]        rd_gnt,
    input  logic                        out_empty,
    output logic                        out_valid,
    output logic [TAG_W-1:0]            out_tag,
    output logic [WARP_W-1:0]           out_warp
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int EW     = CU_W + OP_W;
    localparam int QC_W   = $clog2(Q_DEPTH+1);
    localparam int PN_W   = $clog2(NUM_SRC+1);
    localparam int FC_W   = $clog2(NUM_CU+1);

    typedef struct packed {
        logic [NUM_CU-1:0]                busy;
        logic [NUM_CU-1:0][NUM_SRC-1:0]   pend;
        logic [NUM_CU-1:0][TAG_W-1:0]     tag;
        logic [NUM_CU-1:0][WARP_W-1:0]    warp;
        logic [CU_W-1:0]                  last;
    } oc_st_t;

    oc_st_t s_d, s_q;

    logic [BANK_W-1:0]                         wb_bank;
    logic [NUM_BANKS-1:0]                      rsv, pop, head_vld;
    logic [NUM_BANKS-1:0][EW-1:0]              head;
    logic [NUM_BANKS-1:0][QC_W-1:0]            q_cnt;
    logic [NUM_CU-1:0]                         cu_ready;
    logic                                      disp_vld;
    logic [CU_W-1:0]                           disp_id;
    logic [NUM_SRC-1:0][BANK_W-1:0]            src_bank;
    logic [NUM_BANKS-1:0][PN_W-1:0]            pn, push_n;
    logic [NUM_BANKS-1:0][NUM_SRC-1:0][EW-1:0] pe;
    logic                                      room_all, slot_avail, accept;
    logic [CU_W-1:0]                           alloc_id;
    logic [FC_W-1:0]                           free_cnt;
    logic [NUM_CU-1:0]                         busy_vec;

    // reservation, grantable requests, dispatch pick
    always_comb begin
        wb_bank  = BANK_W'(oc_pkg::bank_of(32'(wb_reg), 32'(wb_warp), NUM_BANKS));
        for (int b = 0; b < NUM_BANKS; b++) begin
            rsv[b]    = wb_valid && (wb_bank == BANK_W'(b));
            rd_req[b] = head_vld[b] && !rsv[b];
            pop[b]    = rd_req[b] && rd_gnt[b];
        end
        for (int c = 0; c < NUM_CU; c++)
            cu_ready[c] = s_q.busy[c] && (s_q.pend[c] == '0);
        disp_vld = 1'b0;
        disp_id  = '0;
        for (int i = 1; i <= NUM_CU; i++) begin
            if (!disp_vld && out_empty && cu_ready[(int'(s_q.last) + i) % NUM_CU]) begin
                disp_vld = 1'b1;
                disp_id  = CU_W'((int'(s_q.last) + i) % NUM_CU);
            end
        end
    end

    // bank mapping of the incoming operands and back-pressure
    always_comb begin
        room_all = 1'b1;
        for (int k = 0; k < NUM_SRC; k++)
            src_bank[k] = BANK_W'(oc_pkg::bank_of(32'(in_src_reg[k*REG_W +: REG_W]),
                                                  32'(in_warp), NUM_BANKS));
        for (int b = 0; b < NUM_BANKS; b++) begin
            int n;
            n = 0;
            for (int k = 0; k < NUM_SRC; k++)
                if (in_src_vld[k] && src_bank[k] == BANK_W'(b)) n++;
            pn[b] = PN_W'(n);
            if (int'(q_cnt[b]) + n > Q_DEPTH) room_all = 1'b0;
        end
        in_ready = slot_avail && room_all;
        accept   = in_valid && in_ready;
        for (int b = 0; b < NUM_BANKS; b++)
            push_n[b] = accept ? pn[b] : '0;
    end

    // compacted per-bank push entries in ascending operand order
    always_comb begin
        pe = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            int n;
            n = 0;
            for (int k = 0; k < NUM_SRC; k++) begin
                if (in_src_vld[k] && src_bank[k] == BANK_W'(b)) begin
                    pe[b][n] = {alloc_id, OP_W'(k)};
                    n++;
                end
            end
        end
    end

    // next state: grants, dispatch, allocation
    always_comb begin
        s_d = s_q;
        for (int b = 0; b < NUM_BANKS; b++)
            if (pop[b]) s_d.pend[head[b][EW-1:OP_W]][head[b][OP_W-1:0]] = 1'b0;
        if (disp_vld) begin
            s_d.busy[disp_id] = 1'b0;
            s_d.last          = disp_id;
        end
        if (accept) begin
            s_d.busy[alloc_id] = 1'b1;
            s_d.pend[alloc_id] = in_src_vld;
            s_d.tag[alloc_id]  = in_tag;
            s_d.warp[alloc_id] = in_warp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        oc_bank_fifo #(.DEPTH(Q_DEPTH), .EW(EW), .NPUSH(NUM_SRC)) u_q (
            .clk(clk), .rst_n(rst_n), .push_n(push_n[b]), .push_e(pe[b]),
            .pop(pop[b]), .head_vld(head_vld[b]), .head(head[b]), .count(q_cnt[b]));
        assign rd_req_cu[b*CU_W +: CU_W] = head[b][EW-1:OP_W];
        assign rd_req_op[b*OP_W +: OP_W] = head[b][OP_W-1:0];
    end

    oc_free_stack #(.N(NUM_CU)) u_free (
        .clk(clk), .rst_n(rst_n), .push(disp_vld), .push_id(disp_id),
        .pop(accept), .pop_id(alloc_id), .avail(slot_avail), .count(free_cnt));

    assign busy_vec  = s_q.busy;
    assign out_valid = disp_vld;
    assign out_tag   = s_q.tag[disp_id];
    assign out_warp  = s_q.warp[disp_id];
endmodule

// File: rtl/oc_checker.sv
module oc_checker #(
    parameter int NUM_CU    = 4,
    parameter int NUM_BANKS = 8,
    parameter int Q_DEPTH   = 8,
    parameter int REG_W     = 8,
    parameter int WARP_W    = 6,
    parameter int CU_W      = $clog2(NUM_CU),
    parameter int QC_W      = $clog2(Q_DEPTH+1),
    parameter int FC_W      = $clog2(NUM_CU+1)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wb_valid,
    input logic [WARP_W-1:0]                 wb_warp,
    input logic [REG_W-1:0]                  wb_reg,
    input logic [NUM_BANKS-1:0]              rd_req,
    input logic [NUM_BANKS*CU_W-1:0]         rd_req_cu,
    input logic                              out_empty,
    input logic                              out_valid,
    input logic [NUM_CU-1:0]                 busy,
    input logic [FC_W-1:0]                   free_cnt,
    input logic [NUM_BANKS-1:0][QC_W-1:0]    q_cnt
);
    int wbb;
    assign wbb = oc_pkg::bank_of(32'(wb_reg), 32'(wb_warp), NUM_BANKS);

    a_r7_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !out_empty |-> !out_valid);

    a_r6_reserved_bank_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !rd_req[wbb]);

    a_r10_pool_balance: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy) + int'(free_cnt)) == NUM_CU);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        a_r10_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(q_cnt[b]) <= Q_DEPTH);
        a_r2_req_owner_busy: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[b] |-> busy[rd_req_cu[b*CU_W +: CU_W]]);
    end
endmodule

bind opnd_collector oc_checker #(
    .NUM_CU(NUM_CU), .NUM_BANKS(NUM_BANKS), .Q_DEPTH(Q_DEPTH),
    .REG_W(REG_W), .WARP_W(WARP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .rd_req(rd_req), .rd_req_cu(rd_req_cu), .out_empty(out_empty), .out_valid(out_valid),
    .busy(busy_vec), .free_cnt(free_cnt), .q_cnt(q_cnt)
);

// File: tb/opnd_collector_tb.sv
module opnd_collector_tb_top;
    localparam int NCU = 4, NB = 8, NS = 4, QD = 8, RW = 8, WW = 6, TW = 8;
    localparam int CW = 2, OW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_ready;
    logic [TW-1:0] in_tag = '0;
    logic [WW-1:0] in_warp = '0;
    logic [NS-1:0] in_src_vld = '0;
    logic [NS*RW-1:0] in_src_reg = '0;
    logic wb_valid = 0;
    logic [WW-1:0] wb_warp = '0;
    logic [RW-1:0] wb_reg = '0;
    logic [NB-1:0] rd_req, rd_gnt = '0;
    logic [NB*CW-1:0] rd_req_cu;
    logic [NB*OW-1:0] rd_req_op;
    logic out_empty = 0, out_valid;
    logic [TW-1:0] out_tag;
    logic [WW-1:0] out_warp;

    opnd_collector dut_i (.*);

    always #5 clk = ~clk;

    // behavioural reference
    bit m_busy[NCU];
    bit m_pend[NCU][NS];
    int m_tag[NCU], m_warp[NCU];
    int m_last;
    int m_free[$];
    int m_q[NB][$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string phase = "";

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    function automatic int bnk(int r, int w);
        return (r + w) % NB;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCU; c++) begin
            m_busy[c] = 0;
            for (int k = 0; k < NS; k++) m_pend[c][k] = 0;
        end
        for (int b = 0; b < NB; b++) m_q[b].delete();
        m_free.delete();
        for (int c = 0; c < NCU; c++) m_free.push_back(c);
        m_last = 0;
    endtask

    task automatic set_in(bit v, int tag, int warp, int r0, int r1, int r2, int r3, bit [3:0] vld);
        in_valid = v; in_tag = TW'(tag); in_warp = WW'(warp); in_src_vld = vld;
        in_src_reg = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
    endtask

    task automatic step();
        int wbb, d, cnt[NB];
        bit req[NB], rm, rdy, allz;
        #1;
        wbb = wb_valid ? bnk(int'(wb_reg), int'(wb_warp)) : -1;
        for (int b = 0; b < NB; b++) req[b] = (m_q[b].size() > 0) && (b != wbb);
        d = -1;
        if (out_empty)
            for (int i = 1; i <= NCU; i++) begin
                int c = (m_last + i) % NCU;
                allz = 1;
                for (int k = 0; k < NS; k++) if (m_pend[c][k]) allz = 0;
                if (d < 0 && m_busy[c] && allz) d = c;
            end
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        for (int k = 0; k < NS; k++)
            if (in_src_vld[k]) cnt[bnk(int'(in_src_reg[k*RW +: RW]), int'(in_warp))]++;
        rm = 1;
        for (int b = 0; b < NB; b++) if (m_q[b].size() + cnt[b] > QD) rm = 0;
        rdy = ((m_free.size() > 0) || d >= 0) && rm;
        chk("in_ready", int'(in_ready), int'(rdy));
        chk("out_valid", int'(out_valid), int'(d >= 0));
        if (d >= 0) begin
            chk("out_tag", int'(out_tag), m_tag[d]);
            chk("out_warp", int'(out_warp), m_warp[d]);
        end
        for (int b = 0; b < NB; b++) begin
            chk($sformatf("rd_req[%0d]", b), int'(rd_req[b]), int'(req[b]));
            if (req[b]) begin
                chk($sformatf("rd_req_cu[%0d]", b), int'(rd_req_cu[b*CW +: CW]), m_q[b][0] / 16);
                chk($sformatf("rd_req_op[%0d]", b), int'(rd_req_op[b*OW +: OW]), m_q[b][0] % 16);
            end
        end
        @(posedge clk);
        for (int b = 0; b < NB; b++)
            if (req[b] && rd_gnt[b]) begin
                int e = m_q[b].pop_front();
                m_pend[e / 16][e % 16] = 0;
            end
        if (d >= 0) begin
            m_busy[d] = 0; m_free.push_back(d); m_last = d;
        end
        if (in_valid && rdy) begin
            int id = m_free.pop_back();
            m_busy[id] = 1; m_tag[id] = int'(in_tag); m_warp[id] = int'(in_warp);
            for (int k = 0; k < NS; k++) begin
                m_pend[id][k] = in_src_vld[k];
                if (in_src_vld[k])
                    m_q[bnk(int'(in_src_reg[k*RW +: RW]), int'(in_warp))].push_back(id * 16 + k);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..all) actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        phase = "R1 reset state";
        step();

        phase = "R4 lifo allocation, R2 bank mapping";
        out_empty = 0;
        set_in(1, 10, 0, 1, 0, 0, 0, 4'b0001); step();  // slot 3, bank 1
        set_in(1, 11, 1, 0, 1, 0, 0, 4'b0010); step();  // slot 2, bank 2 op1
        set_in(1, 12, 0, 3, 0, 11, 0, 4'b0101); step(); // slot 1, bank 3 twice
        phase = "R9 no-source instruction";
        set_in(1, 13, 2, 0, 0, 0, 0, 4'b0000); step();  // slot 0
        phase = "R3 no free slot";
        set_in(1, 14, 0, 5, 0, 0, 0, 4'b0001); step();
        set_in(0, 0, 0, 0, 0, 0, 0, 4'b0000);

        phase = "R6 write reserves bank";
        wb_valid = 1; wb_reg = 2; wb_warp = 0;
        rd_gnt = 8'b0000_0100; step(); step();
        wb_valid = 0;
        phase = "R5 grant on idle bank ignored";
        rd_gnt = 8'b0100_0000; step();

        phase = "R5 grants clear operands, R2 fifo order";
        rd_gnt = '1; step(); step(); step();
        rd_gnt = '0;
        phase = "R7 ready but blocked";
        step(); step();

        phase = "R8 round robin, R4 same-cycle reuse, R9";
        out_empty = 1;
        set_in(1, 20, 3, 0, 0, 0, 0, 4'b0000); step();
        set_in(0, 0, 0, 0, 0, 0, 0, 4'b0000);
        repeat (6) step();

        phase = "R3 R10 bank queue full";
        out_empty = 0;
        set_in(1, 30, 0, 0, 8, 16, 24, 4'b1111); step();
        set_in(1, 31, 0, 32, 40, 48, 56, 4'b1111); step();
        set_in(1, 32, 0, 64, 0, 0, 0, 4'b0001); step(); step();
        set_in(1, 33, 0, 1, 0, 0, 0, 4'b0001); step();
        set_in(0, 0, 0, 0, 0, 0, 0, 4'b0000);
        phase = "R5 R7 drain";
        out_empty = 1; rd_gnt = '1;
        repeat (12) step();

        phase = "R2 R5 R6 R7 R8 mixed traffic";
        for (int n = 0; n < 600; n++) begin
            set_in(($urandom % 3) != 0, int'($urandom % 256), int'($urandom % 64),
                   int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
                   int'($urandom % 256), 4'($urandom));
            wb_valid = ($urandom % 3) == 0;
            wb_reg = RW'($urandom); wb_warp = WW'($urandom);
            rd_gnt = NB'($urandom) & NB'($urandom);
            out_empty = ($urandom % 10) < 7;
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule